// File: doc/BRIEF.md
# Multi-channel TDC FIFO readout sequencer

This block collects time-to-digital converter hits in one small FIFO per channel and drains them as packets on a valid/ready stream. While an acquisition window is open it only stores hits. It raises `busy` when any channel runs close to full, so that an external window controller can close the window early.

When the window-end signal rises, the sequencer stamps the event. The stamp holds a running window number and a coarse timestamp that counts 200 ns periods. It sends this as a two-word event packet. It then walks the channels from lowest to highest index and sends one packet for each channel that holds data. `busy` stays high for the whole drain and drops when the last channel has been visited.

An optional trigger mode treats channel 0 as the trigger input. If channel 0 holds no hit when the window closes, the event is thrown away. Every FIFO is wiped in a single cycle and nothing is sent, which keeps dead time short.

Top module: `tdc_readout_seq`

## Requirements
- R1: Each channel FIFO holds FIFO_DEPTH (32) words. A write to a full FIFO is dropped, so a channel packet never reports more than 32 words.
- R2: `busy` is high in every cycle in which any FIFO holds at least AF_LEVEL (25) words. While idle with all FIFOs below that level, `busy` is low.
- R3: A rising edge of `windowEnd` seen while idle starts a transfer. `busy` is high from the next cycle until the transfer ends. A level held high, or an edge during a transfer, starts nothing.
- R4: Each transfer first sends an event packet of two words. The first word is bits 31:24 = 0xE0, bits 23:16 = 0 and bits 15:0 = the window number. The second word is the 32-bit timestamp. The window number counts accepted window ends, starting at 0. The timestamp starts at 0 at reset and advances once every TICK_DIV (25) clocks. Both values are the ones held at the clock edge where the edge is accepted.
- R5: After the event packet, channels are visited in ascending index order. A channel with data sends a header word: bits 31:24 = 0xC0, bits 23:16 = channel index, bits 15:0 = word count taken at its visit. The header is followed by that many data words, oldest first, each with the FIFO word in bits 15:0 and zeros above. Empty channels send nothing.
- R6: `outLast` is high exactly on the final word of each packet: the second event word, and the last data word of a channel packet.
- R7: While `outValid` is high and `outReady` is low, the word on `outData` and `outLast` holds, and the sequence does not advance.
- R8: After the last channel has been visited, the sequencer returns to idle. `busy` then follows only the fill levels.
- R9: In trigger mode (`trigMode` high at the accepting edge), if channel 0 is empty, every FIFO is cleared in one cycle and nothing is sent. Writes in that clearing cycle are dropped. The window number still advances.
- R10: In trigger mode with channel 0 not empty, the transfer is identical to the non-trigger transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | NUM_CH | Per-channel hit write strobe |
| wrData | input | NUM_CH*DATA_W | Per-channel hit words, channel g in slice g |
| windowEnd | input | 1 | Acquisition window end, rising edge used |
| trigMode | input | 1 | Selects trigger mode |
| busy | output | 1 | Hold-off to the window controller |
| outValid | output | 1 | Stream word valid |
| outReady | input | 1 | Stream sink ready |
| outData | output | 32 | Stream word |
| outLast | output | 1 | Final word of a packet |

## Verification
Some rules can be checked in every cycle. These are:
- the stream word and its last flag hold stable under back-pressure;
- `busy` covers every valid word;
- a clear empties a FIFO and a write to a full FIFO leaves it full;
- the window number moves only on an accepted edge;
- the channel index never goes backwards within a transfer.

Other behaviour shows only in the bench's scenarios, where a behavioural queue model is compared on every clock. This covers packet contents and order, timestamp values, the count cap on overflow, the ignored held level and mid-transfer edges, and the trigger-mode flush that leaves a later window with no channel packets.

// File: rtl/tdc_seq_pkg.sv
package tdc_seq_pkg;
  localparam int OUT_W  = 32;
  localparam int GTC_W  = 16;
  localparam int BCID_W = 32;
  localparam int LEN_W  = 16;
  localparam int CHI_W  = 8;

  localparam logic [7:0] EVT_TAG = 8'hE0;
  localparam logic [7:0] CH_TAG  = 8'hC0;

  typedef enum logic [2:0] {
    S_IDLE, S_TRIG, S_CLEAR, S_EVT0, S_EVT1, S_SCAN, S_CHDR, S_DATA
  } seqState_t;

  typedef enum logic [1:0] {W_EVT0, W_EVT1, W_CHDR, W_DATA} wordSel_t;

  typedef struct packed {
    logic             capture;
    logic             clearAll;
    logic             pop;
    wordSel_t         wordSel;
    logic [CHI_W-1:0] chSel;
    logic [LEN_W-1:0] pktLen;
  } seqStrobe_t;
endpackage

// File: rtl/tdc_chan_fifo.sv
module tdc_chan_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clr,
  input  logic                        wrEn,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        pop,
  output logic [DATA_W-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0]  level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] cnt;
  logic full, doWr, doRd;

  assign full = (cnt == CW'(DEPTH));
  assign doWr = wrEn && !full && !clr;
  assign doRd = pop && (cnt != '0) && !clr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + AW'(1);
      if (doRd) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + AW'(1);
      cnt <= cnt + CW'(doWr) - CW'(doRd);
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  assign head  = mem[rdPtr];
  assign level = cnt;

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (level == '0));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == CW'(DEPTH) && wrEn && !pop && !clr) |=> (level == CW'(DEPTH)));
endmodule

// File: rtl/tdc_seq_datapath.sv
module tdc_seq_datapath
  import tdc_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int AF_LEVEL   = 25,
  parameter int TICK_DIV   = 25
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        wrEn,
  input  logic [NUM_CH*DATA_W-1:0] wrData,
  input  seqStrobe_t               strb,
  output logic [LEN_W-1:0]         selLevel,
  output logic                     trigEmpty,
  output logic                     anyAlmostFull,
  output logic [OUT_W-1:0]         outData
);
  localparam int CW    = $clog2(FIFO_DEPTH+1);
  localparam int CHS_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int TW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DATA_W-1:0] heads [NUM_CH];
  logic [CW-1:0]     lvl   [NUM_CH];
  logic [NUM_CH-1:0] afVec;
  logic [CHS_W-1:0]  selIdx;

  assign selIdx = strb.chSel[CHS_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic popG;
    assign popG = strb.pop && (strb.chSel == CHI_W'(g));
    tdc_chan_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) uFifo (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strb.clearAll),
      .wrEn   (wrEn[g]),
      .wrData (wrData[g*DATA_W +: DATA_W]),
      .pop    (popG),
      .head   (heads[g]),
      .level  (lvl[g])
    );
    assign afVec[g] = (lvl[g] >= CW'(AF_LEVEL));
  end

  assign anyAlmostFull = |afVec;
  assign trigEmpty     = (lvl[0] == '0);
  assign selLevel      = LEN_W'(lvl[selIdx]);

  logic [TW-1:0]     tick;
  logic [BCID_W-1:0] bcid, bcidCap;
  logic [GTC_W-1:0]  gtc, gtcCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick    <= '0;
      bcid    <= '0;
      gtc     <= '0;
      gtcCap  <= '0;
      bcidCap <= '0;
    end else begin
      if (tick == TW'(TICK_DIV-1)) begin
        tick <= '0;
        bcid <= bcid + BCID_W'(1);
      end else begin
        tick <= tick + TW'(1);
      end
      if (strb.capture) begin
        gtcCap  <= gtc;
        bcidCap <= bcid;
        gtc     <= gtc + GTC_W'(1);
      end
    end
  end

  always_comb begin
    case (strb.wordSel)
      W_EVT0:  outData = {EVT_TAG, 8'h00, gtcCap};
      W_EVT1:  outData = bcidCap;
      W_CHDR:  outData = {CH_TAG, strb.chSel, strb.pktLen};
      default: outData = {{(OUT_W-DATA_W){1'b0}}, heads[selIdx]};
    endcase
  end

  // R4
  gtc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gtc) |-> $past(strb.capture));
endmodule

// File: rtl/tdc_seq_ctrl.sv
module tdc_seq_ctrl
  import tdc_seq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             windowEnd,
  input  logic             trigMode,
  input  logic             outReady,
  input  logic [LEN_W-1:0] selLevel,
  input  logic             trigEmpty,
  output seqStrobe_t       strb,
  output logic             outValid,
  output logic             outLast,
  output logic             inTransfer
);
  seqState_t        state;
  logic [CHI_W-1:0] chIdx;
  logic [LEN_W-1:0] remLen;
  logic             wePrev, weRise, lastCh;

  assign weRise = windowEnd && !wePrev;
  assign lastCh = (chIdx == CHI_W'(NUM_CH-1));

  always_comb begin
    strb          = '0;
    strb.wordSel  = W_DATA;
    strb.chSel    = chIdx;
    strb.pktLen   = remLen;
    case (state)
      S_IDLE:  strb.capture  = weRise;
      S_CLEAR: strb.clearAll = 1'b1;
      S_EVT0:  strb.wordSel  = W_EVT0;
      S_EVT1:  strb.wordSel  = W_EVT1;
      S_CHDR:  strb.wordSel  = W_CHDR;
      S_DATA:  strb.pop      = outReady;
      default: ;
    endcase
  end

  assign outValid   = (state == S_EVT0) || (state == S_EVT1) ||
                      (state == S_CHDR) || (state == S_DATA);
  assign outLast    = (state == S_EVT1) ||
                      ((state == S_DATA) && (remLen == LEN_W'(1)));
  assign inTransfer = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      chIdx  <= '0;
      remLen <= '0;
      wePrev <= 1'b0;
    end else begin
      wePrev <= windowEnd;
      case (state)
        S_IDLE: if (weRise) begin
          chIdx <= '0;
          state <= trigMode ? S_TRIG : S_EVT0;
        end
        S_TRIG:  state <= trigEmpty ? S_CLEAR : S_EVT0;
        S_CLEAR: state <= S_IDLE;
        S_EVT0:  if (outReady) state <= S_EVT1;
        S_EVT1:  if (outReady) state <= S_SCAN;
        S_SCAN: begin
          if (selLevel == '0) begin
            if (lastCh) state <= S_IDLE;
            else chIdx <= chIdx + CHI_W'(1);
          end else begin
            remLen <= selLevel;
            state  <= S_CHDR;
          end
        end
        S_CHDR: if (outReady) state <= S_DATA;
        S_DATA: if (outReady) begin
          remLen <= remLen - LEN_W'(1);
          if (remLen == LEN_W'(1)) begin
            if (lastCh) state <= S_IDLE;
            else begin
              chIdx <= chIdx + CHI_W'(1);
              state <= S_SCAN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  scan_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) != S_IDLE) |-> (chIdx >= $past(chIdx)));
endmodule

// File: rtl/tdc_readout_seq.sv
module tdc_readout_seq
  import tdc_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int AF_LEVEL   = 25,
  parameter int TICK_DIV   = 25
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        wrEn,
  input  logic [NUM_CH*DATA_W-1:0] wrData,
  input  logic                     windowEnd,
  input  logic                     trigMode,
  output logic                     busy,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [31:0]              outData,
  output logic                     outLast
);
  seqStrobe_t       strb;
  logic [LEN_W-1:0] selLevel;
  logic             trigEmpty, anyAlmostFull, inTransfer;

  tdc_seq_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .windowEnd  (windowEnd),
    .trigMode   (trigMode),
    .outReady   (outReady),
    .selLevel   (selLevel),
    .trigEmpty  (trigEmpty),
    .strb       (strb),
    .outValid   (outValid),
    .outLast    (outLast),
    .inTransfer (inTransfer)
  );

  tdc_seq_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH),
    .AF_LEVEL(AF_LEVEL), .TICK_DIV(TICK_DIV)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .wrData        (wrData),
    .strb          (strb),
    .selLevel      (selLevel),
    .trigEmpty     (trigEmpty),
    .anyAlmostFull (anyAlmostFull),
    .outData       (outData)
  );

  assign busy = inTransfer || anyAlmostFull;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R3
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);
endmodule

// File: tb/sim_tdc_readout_seq.sv
module sim_tdc_readout_seq;
  localparam int NCH = 4, DW = 16, DEPTH = 32, AF = 25, TDIV = 25;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]    wrEn = '0;
  logic [NCH*DW-1:0] wrData = '0;
  logic windowEnd = 1'b0, trigMode = 1'b0, outReady = 1'b1;
  logic busy, outValid, outLast;
  logic [31:0] outData;

  tdc_readout_seq #(.NUM_CH(NCH), .DATA_W(DW), .FIFO_DEPTH(DEPTH),
                    .AF_LEVEL(AF), .TICK_DIV(TDIV)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .windowEnd(windowEnd), .trigMode(trigMode), .busy(busy),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast));

  int total = 0, bad = 0;
  int readyPat = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] mq [NCH][$];
  int mMode = 0, mCh = 0, mRem = 0, mGtc = 0, mTick = 0, mBcid = 0;
  int mGtcCap = 0, mBcidCap = 0;
  int sz [NCH];
  bit mPrev = 1'b0, wasClear, rise;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCh = 0; mRem = 0; mGtc = 0; mTick = 0; mBcid = 0;
      mGtcCap = 0; mBcidCap = 0; mPrev = 1'b0;
      for (int c = 0; c < NCH; c++) mq[c].delete();
    end else begin
      for (int c = 0; c < NCH; c++) sz[c] = mq[c].size();
      rise = windowEnd && !mPrev;
      wasClear = (mMode == 2);
      case (mMode)
        0: if (rise) begin
             mGtcCap = mGtc; mBcidCap = mBcid; mGtc++; mCh = 0;
             mMode = trigMode ? 1 : 3;
           end
        1: mMode = (sz[0] == 0) ? 2 : 3;
        2: begin
             for (int c = 0; c < NCH; c++) mq[c].delete();
             mMode = 0;
           end
        3: if (outReady) mMode = 4;
        4: if (outReady) mMode = 5;
        5: if (sz[mCh] == 0) begin
             if (mCh == NCH-1) mMode = 0; else mCh++;
           end else begin
             mRem = sz[mCh]; mMode = 6;
           end
        6: if (outReady) mMode = 7;
        7: if (outReady) begin
             void'(mq[mCh].pop_front());
             mRem--;
             if (mRem == 0) begin
               if (mCh == NCH-1) mMode = 0;
               else begin mCh++; mMode = 5; end
             end
           end
        default: mMode = 0;
      endcase
      if (!wasClear)
        for (int c = 0; c < NCH; c++)
          if (wrEn[c] && sz[c] < DEPTH) mq[c].push_back(wrData[c*DW +: DW]);
      if (mTick == TDIV-1) begin mTick = 0; mBcid++; end else mTick++;
      mPrev = windowEnd;
    end
  end

  // per-cycle comparison, away from the active edge
  logic [31:0] got [$];
  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic bit anyAf = 1'b0;
      automatic bit eV;
      automatic bit eL;
      automatic logic [31:0] eD;
      automatic string tg;
      for (int c = 0; c < NCH; c++) if (mq[c].size() >= AF) anyAf = 1'b1;
      chk(busy == ((mMode != 0) || anyAf), (mMode != 0) ? "R3 busy" : "R2 busy",
          32'(busy), 32'((mMode != 0) || anyAf));
      eV = (mMode == 3) || (mMode == 4) || (mMode == 6) || (mMode == 7);
      chk(outValid == eV, outReady ? "R5 valid" : "R7 valid", 32'(outValid), 32'(eV));
      if (eV) begin
        case (mMode)
          3: begin eD = {8'hE0, 8'h00, 16'(mGtcCap)}; tg = "R4 event word0"; end
          4: begin eD = 32'(mBcidCap); tg = "R4 event word1"; end
          6: begin eD = {8'hC0, 8'(mCh), 16'(mRem)}; tg = "R5 channel header"; end
          default: begin eD = {16'h0, mq[mCh][0]}; tg = "R5 data word"; end
        endcase
        if (!outReady) tg = {tg, " R7"};
        eL = (mMode == 4) || (mMode == 7 && mRem == 1);
        chk(outData == eD, tg, outData, eD);
        chk(outLast == eL, "R6 last", 32'(outLast), 32'(eL));
      end
      if (outValid && outReady) got.push_back(outData);
    end
  end

  always @(posedge clk) begin
    #2;
    outReady = (readyPat == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pushWords(input int ch, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wrEn = '0;
      wrEn[ch] = 1'b1;
      wrData[ch*DW +: DW] = DW'(base + i);
      step();
    end
    wrEn = '0;
  endtask

  task automatic pulseWindow();
    windowEnd = 1'b1; step();
    windowEnd = 1'b0; step();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && mMode != 0; i++) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // reset state, R3 R2
    chk(busy == 1'b0, "R3 reset busy", 32'(busy), 32'h0);
    chk(outValid == 1'b0, "R3 reset valid", 32'(outValid), 32'h0);
    rstN = 1'b1;
    step(); step();

    // scenario 1: plain transfer, R5 R8
    readyPat = 0;
    pushWords(1, 3, 16'h100);
    pushWords(3, 1, 16'h300);
    repeat (30) step();
    got.delete();
    pulseWindow(); waitIdle();
    chk(got.size() == 8, "R5 packet word total", 32'(got.size()), 32'd8);
    if (got.size() > 2)
      chk(got[2] == 32'hC001_0003, "R5 first channel header", got[2], 32'hC001_0003);
    chk(busy == 1'b0, "R8 busy released", 32'(busy), 32'h0);

    // scenario 2: back-pressure and held window level, R7 R3
    readyPat = 1;
    pushWords(0, 2, 16'h010);
    pushWords(2, 5, 16'h220);
    got.delete();
    windowEnd = 1'b1;
    repeat (100) step();
    windowEnd = 1'b0;
    waitIdle(); repeat (5) step();
    chk(got.size() == 11, "R3 held level one event", 32'(got.size()), 32'd11);

    // scenario 3: almost full, overflow, mid-transfer edge, R2 R1 R3
    pushWords(2, 24, 16'h2000);
    chk(busy == 1'b0, "R2 below level", 32'(busy), 32'h0);
    pushWords(2, 1, 16'h2018);
    chk(busy == 1'b1, "R2 at level", 32'(busy), 32'h1);
    pushWords(2, 15, 16'h2019);
    got.delete();
    pulseWindow();
    repeat (5) step();
    pulseWindow();
    waitIdle();
    chk(got.size() == 35, "R3 mid-transfer edge ignored", 32'(got.size()), 32'd35);
    if (got.size() > 2)
      chk(got[2] == 32'hC002_0020, "R1 count capped", got[2], 32'hC002_0020);
    if (got.size() > 34)
      chk(got[34] == 32'h0000_201F, "R5 oldest first", got[34], 32'h0000_201F);

    // scenario 4: trigger flush, R9
    readyPat = 0;
    trigMode = 1'b1;
    pushWords(1, 4, 16'h140);
    pushWords(2, 2, 16'h240);
    got.delete();
    windowEnd = 1'b1; wrEn[3] = 1'b1; wrData[3*DW +: DW] = 16'h3333;
    step();
    windowEnd = 1'b0; step(); step();
    wrEn = '0;
    waitIdle();
    chk(got.size() == 0, "R9 nothing sent", 32'(got.size()), 32'd0);
    trigMode = 1'b0;
    got.delete();
    pulseWindow(); waitIdle();
    chk(got.size() == 2, "R9 fifos cleared", 32'(got.size()), 32'd2);
    if (got.size() > 0)
      chk(got[0] == 32'hE000_0004, "R4 window number", got[0], 32'hE000_0004);

    // scenario 5: trigger with hit, R10
    trigMode = 1'b1;
    readyPat = 1;
    pushWords(0, 1, 16'h0AA);
    pushWords(3, 2, 16'h3BB);
    got.delete();
    pulseWindow(); waitIdle(); repeat (5) step();
    chk(got.size() == 7, "R10 trigger pass", 32'(got.size()), 32'd7);
    trigMode = 1'b0;

    repeat (5) step();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule